// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Word Reader

This block is a bus master that fetches 16-bit words from a three-wire serial EEPROM. A host hands it a word address. It then raises the memory's chip select with the shift clock low and sends a read command of three bits, the leading start bit already folded in, followed by the address, most significant bit first. After the address it clocks in sixteen data bits, most significant bit first, and drops chip select. The memory sees a slow bit clock. Each of its low and high phases lasts `PHASE_CLKS` system clocks, so the part's minimum pulse widths are met. Write and erase commands are never issued.

Two families of memory answer to this command, one with 6-bit and one with 8-bit word addresses. The host can pick the width per request. It can also ask for auto-detection. In that mode the block first reads word 0 with 8-bit addressing. If word 0 holds the signature 0x8129, the target is an 8-bit-address part; otherwise it is a 6-bit part. The block then reads the requested word at the width it found and reports that width with the data.

The host side uses valid/ready handshakes. A request is taken in a cycle where `req_valid` and `req_ready` are both high. `req_ready` is low while a transfer runs and while a response waits. A response is offered with `rsp_valid`. It holds `rsp_data` and `rsp_wide` unchanged until a cycle with `rsp_ready` high. The next request cannot be taken before that cycle, so a host that stalls the response also stalls the memory. `busy` is a plain status pin.

Top module: `mw_eeprom_reader`

## Requirements
- R1: After reset, `mem_cs`, `mem_clk` and `mem_mosi` are 0, `rsp_valid` and `busy` are 0, and `req_ready` is 1.
- R2: Every transfer sends the opcode bits 1,1,0 and then the address, MSB-first, for 3+W bits in all. W is 8 when the transfer is wide, and then the address is `req_addr[7:0]`. Otherwise W is 6 and the address is `req_addr[5:0]`, with the upper bits ignored. No other opcode (such as 1,0,1 or 1,1,1) is ever sent.
- R3: `mem_cs` rises only while `mem_clk` is low, and it falls only after `mem_clk` has been low for at least a cycle.
- R4: `mem_mosi` does not change while `mem_clk` is high. Every high phase of `mem_clk` lasts exactly `PHASE_CLKS` clocks.
- R5: After the command, exactly 16 rising edges of `mem_clk` occur, so one select window holds 3+W+16 rising edges. `mem_miso` is sampled while `mem_clk` is high, and the first bit sampled lands in `rsp_data[15]`.
- R6: With `req_auto`=1, word 0 is first read with W=8. W for the requested word is 8 if that word equals 0x8129, and 6 otherwise; `req_wide` is ignored. With `req_auto`=0, W comes from `req_wide` (1 means 8). `rsp_wide` reports the W used (1 means 8).
- R7: While `rsp_valid`=1 and `rsp_ready`=0, `rsp_valid`, `rsp_data` and `rsp_wide` hold, `req_ready` is 0, and a presented request is not taken, so `mem_cs` stays low.
- R8: `busy` rises in the cycle after a request is taken. It stays high until the memory has been deselected for at least `PHASE_CLKS` clocks, and it is low whenever `rsp_valid` is high. `mem_cs` is never high while `busy` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request can be taken |
| req_addr | input | ADDR_MAX (8) | Word address |
| req_wide | input | 1 | 1: 8-bit address, 0: 6-bit address (ignored in auto mode) |
| req_auto | input | 1 | Detect the address width from word 0 |
| rsp_valid | output | 1 | Read word available |
| rsp_ready | input | 1 | Host takes the word |
| rsp_data | output | DATA_W (16) | Word read, first bit received in the MSB |
| rsp_wide | output | 1 | Address width used: 1 means 8 bits |
| busy | output | 1 | Transfer in progress |
| mem_cs | output | 1 | Memory chip select, active high |
| mem_clk | output | 1 | Memory shift clock |
| mem_mosi | output | 1 | Serial data to the memory |
| mem_miso | input | 1 | Serial data from the memory |

## Verification
If the bit counter is wrong, the memory sees the wrong number of rising clock edges in the select window, so its address is misread. The error shows in the returned word and in the edge count within one transfer. If the phase timer or the phase state is wrong, a clock high phase of the wrong length appears, or the data line moves under a high clock, at the first affected bit. A fault in the width decision of auto mode shows up only in the second transfer, as a wrong `rsp_wide` and a shifted address. A memory model in the bench decodes the opcode and address exactly as a real part would.

// File: rtl/mw_pkg.sv
package mw_pkg;
  // phases of one serial transfer
  typedef enum logic [2:0] {
    PH_IDLE, PH_SEL, PH_CLO, PH_CHI, PH_DLO, PH_DHI, PH_TAIL, PH_GAP
  } mw_phase_e;

  // read command with the leading start bit folded in
  localparam logic [2:0] RD_OP = 3'b110;

  typedef enum logic [1:0] {
    SQ_IDLE, SQ_PROBE, SQ_MAIN, SQ_RESP
  } mw_seq_e;
endpackage

// File: rtl/mw_phase_timer.sv
module mw_phase_timer #(
  parameter int PHASE_CLKS = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic expire
);
  localparam int CW = $clog2(PHASE_CLKS + 1);
  localparam logic [CW-1:0] LAST = CW'(PHASE_CLKS - 1);

  logic [CW-1:0] cnt;

  assign expire = run && (cnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt <= '0;
    else if (!run)   cnt <= '0;
    else if (expire) cnt <= '0;
    else             cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/mw_bit_engine.sv
module mw_bit_engine
  import mw_pkg::*;
#(
  parameter int ADDR_MAX   = 8,
  parameter int ADDR_MIN   = 6,
  parameter int DATA_W     = 16,
  parameter int PHASE_CLKS = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic                wide,
  input  logic [ADDR_MAX-1:0] addr,
  output logic                eng_busy,
  output logic                done,
  output logic [DATA_W-1:0]   rdata,
  output logic                mem_cs,
  output logic                mem_clk,
  output logic                mem_mosi,
  input  logic                mem_miso
);
  localparam int CMD_W  = 3 + ADDR_MAX;
  localparam int NAR_W  = 3 + ADDR_MIN;
  localparam int MAXB   = (CMD_W > DATA_W) ? CMD_W : DATA_W;
  localparam int CNT_W  = $clog2(MAXB + 1);
  localparam int PAD_W  = ADDR_MAX - ADDR_MIN;

  mw_phase_e          state;
  logic [CMD_W-1:0]   cmd_sr;
  logic [CNT_W-1:0]   bits_left;
  logic [DATA_W-1:0]  data_sr;
  logic               expire;

  mw_phase_timer #(.PHASE_CLKS(PHASE_CLKS)) u_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .run    (state != PH_IDLE),
    .expire (expire)
  );

  logic [CMD_W-1:0] cmd_load;
  generate
    if (PAD_W > 0) begin : g_pad
      assign cmd_load = wide ? {RD_OP, addr}
                             : {RD_OP, addr[ADDR_MIN-1:0], {PAD_W{1'b0}}};
    end else begin : g_nopad
      assign cmd_load = {RD_OP, addr};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= PH_IDLE;
      cmd_sr    <= '0;
      bits_left <= '0;
      data_sr   <= '0;
      done      <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (state)
        PH_IDLE: if (start) begin
          cmd_sr    <= cmd_load;
          bits_left <= wide ? CNT_W'(CMD_W) : CNT_W'(NAR_W);
          state     <= PH_SEL;
        end
        PH_SEL: if (expire) state <= PH_CLO;
        PH_CLO: if (expire) state <= PH_CHI;
        PH_CHI: if (expire) begin
          cmd_sr <= cmd_sr << 1;
          if (bits_left == CNT_W'(1)) begin
            bits_left <= CNT_W'(DATA_W);
            state     <= PH_DLO;
          end else begin
            bits_left <= bits_left - 1'b1;
            state     <= PH_CLO;
          end
        end
        PH_DLO: if (expire) state <= PH_DHI;
        PH_DHI: if (expire) begin
          data_sr <= {data_sr[DATA_W-2:0], mem_miso};
          if (bits_left == CNT_W'(1)) begin
            state <= PH_TAIL;
          end else begin
            bits_left <= bits_left - 1'b1;
            state     <= PH_DLO;
          end
        end
        PH_TAIL: if (expire) state <= PH_GAP;
        PH_GAP: if (expire) begin
          state <= PH_IDLE;
          done  <= 1'b1;
        end
        default: state <= PH_IDLE;
      endcase
    end
  end

  assign eng_busy = (state != PH_IDLE);
  assign mem_cs   = (state != PH_IDLE) && (state != PH_GAP);
  assign mem_clk  = (state == PH_CHI) || (state == PH_DHI);
  assign mem_mosi = ((state == PH_CLO) || (state == PH_CHI)) && cmd_sr[CMD_W-1];
  assign rdata    = data_sr;

  // R4: data line steady through a clock high phase
  a_r4_mosi_steady: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_clk && $past(mem_clk)) |-> $stable(mem_mosi));

  // R3: select rises with the clock low
  a_r3_cs_rise_clk_low: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_cs) |-> !mem_clk);

  // R3: select falls only after a low clock cycle
  a_r3_cs_fall_clk_low: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_cs) |-> (!mem_clk && !$past(mem_clk)));
endmodule

// File: rtl/mw_sequencer.sv
module mw_sequencer
  import mw_pkg::*;
#(
  parameter int              ADDR_MAX  = 8,
  parameter int              DATA_W    = 16,
  parameter logic [DATA_W-1:0] SIGNATURE = 16'h8129
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic [ADDR_MAX-1:0] req_addr,
  input  logic                req_wide,
  input  logic                req_auto,
  output logic                rsp_valid,
  input  logic                rsp_ready,
  output logic [DATA_W-1:0]   rsp_data,
  output logic                rsp_wide,
  output logic                busy,
  output logic                eng_start,
  output logic                eng_wide,
  output logic [ADDR_MAX-1:0] eng_addr,
  input  logic                eng_busy,
  input  logic                eng_done,
  input  logic [DATA_W-1:0]   eng_rdata
);
  mw_seq_e             st;
  logic [ADDR_MAX-1:0] addr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= SQ_IDLE;
      addr_q    <= '0;
      eng_start <= 1'b0;
      eng_wide  <= 1'b0;
      eng_addr  <= '0;
      rsp_data  <= '0;
      rsp_wide  <= 1'b0;
    end else begin
      eng_start <= 1'b0;
      unique case (st)
        SQ_IDLE: if (req_valid) begin
          addr_q    <= req_addr;
          eng_start <= 1'b1;
          if (req_auto) begin
            eng_wide <= 1'b1;
            eng_addr <= '0;
            st       <= SQ_PROBE;
          end else begin
            eng_wide <= req_wide;
            eng_addr <= req_addr;
            st       <= SQ_MAIN;
          end
        end
        SQ_PROBE: if (eng_done) begin
          eng_wide  <= (eng_rdata == SIGNATURE);
          eng_addr  <= addr_q;
          eng_start <= 1'b1;
          st        <= SQ_MAIN;
        end
        SQ_MAIN: if (eng_done) begin
          rsp_data <= eng_rdata;
          rsp_wide <= eng_wide;
          st       <= SQ_RESP;
        end
        SQ_RESP: if (rsp_ready) st <= SQ_IDLE;
        default: st <= SQ_IDLE;
      endcase
    end
  end

  assign req_ready = (st == SQ_IDLE);
  assign rsp_valid = (st == SQ_RESP);
  assign busy      = (st == SQ_PROBE) || (st == SQ_MAIN);

  // R7: a stalled response holds its value
  a_r7_rsp_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data) && $stable(rsp_wide)));

  // R8: a transfer is launched only into an idle engine
  a_r8_start_idle: assert property (@(posedge clk) disable iff (!rst_n)
    eng_start |-> !eng_busy);
endmodule

// File: rtl/mw_eeprom_reader.sv
module mw_eeprom_reader #(
  parameter int                PHASE_CLKS = 4,
  parameter int                ADDR_MAX   = 8,
  parameter int                ADDR_MIN   = 6,
  parameter int                DATA_W     = 16,
  parameter logic [DATA_W-1:0] SIGNATURE  = 16'h8129
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic [ADDR_MAX-1:0] req_addr,
  input  logic                req_wide,
  input  logic                req_auto,
  output logic                rsp_valid,
  input  logic                rsp_ready,
  output logic [DATA_W-1:0]   rsp_data,
  output logic                rsp_wide,
  output logic                busy,
  output logic                mem_cs,
  output logic                mem_clk,
  output logic                mem_mosi,
  input  logic                mem_miso
);
  logic                eng_start;
  logic                eng_wide;
  logic [ADDR_MAX-1:0] eng_addr;
  logic                eng_busy;
  logic                eng_done;
  logic [DATA_W-1:0]   eng_rdata;

  mw_sequencer #(
    .ADDR_MAX  (ADDR_MAX),
    .DATA_W    (DATA_W),
    .SIGNATURE (SIGNATURE)
  ) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_addr  (req_addr),
    .req_wide  (req_wide),
    .req_auto  (req_auto),
    .rsp_valid (rsp_valid),
    .rsp_ready (rsp_ready),
    .rsp_data  (rsp_data),
    .rsp_wide  (rsp_wide),
    .busy      (busy),
    .eng_start (eng_start),
    .eng_wide  (eng_wide),
    .eng_addr  (eng_addr),
    .eng_busy  (eng_busy),
    .eng_done  (eng_done),
    .eng_rdata (eng_rdata)
  );

  mw_bit_engine #(
    .ADDR_MAX   (ADDR_MAX),
    .ADDR_MIN   (ADDR_MIN),
    .DATA_W     (DATA_W),
    .PHASE_CLKS (PHASE_CLKS)
  ) u_eng (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (eng_start),
    .wide     (eng_wide),
    .addr     (eng_addr),
    .eng_busy (eng_busy),
    .done     (eng_done),
    .rdata    (eng_rdata),
    .mem_cs   (mem_cs),
    .mem_clk  (mem_clk),
    .mem_mosi (mem_mosi),
    .mem_miso (mem_miso)
  );

  // R8: memory deselected whenever the block is not busy
  a_r8_idle_cs_low: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mem_cs);

  // R8: busy and a pending response exclude each other
  a_r8_busy_vs_rsp: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !busy);
endmodule

// File: tb/test_mw_eeprom_reader.sv
`timescale 1ns/1ps
module test_mw_eeprom_reader;
  localparam int PH = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_wide = 1'b0, req_auto = 1'b0, rsp_ready = 1'b1;
  logic [7:0] req_addr = '0;
  logic req_ready, rsp_valid, rsp_wide, busy, mem_cs, mem_clk, mem_mosi;
  logic [15:0] rsp_data;
  logic miso_r = 1'b0;

  always #10 clk = ~clk;

  mw_eeprom_reader #(.PHASE_CLKS(PH)) i_mw_eeprom_reader (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_wide(req_wide), .req_auto(req_auto),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data),
    .rsp_wide(rsp_wide), .busy(busy), .mem_cs(mem_cs), .mem_clk(mem_clk),
    .mem_mosi(mem_mosi), .mem_miso(miso_r)
  );

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // memory contents as the bench defines them
  function automatic logic [15:0] ref_word(input logic [7:0] a, input logic mw);
    logic [7:0] i;
    i = mw ? a : {2'b00, a[5:0]};
    if (i == 8'h00) return mw ? 16'h8129 : 16'h1234;
    return {i ^ 8'h5A, ~i};
  endfunction

  // ---------------- serial memory model ----------------
  logic model_wide = 1'b1;
  int m_edges = 0;
  logic [2:0] m_op = '0;
  logic [7:0] m_addr = '0;
  logic [15:0] m_word = '0;
  int last_edges = 0;
  logic [2:0] last_op = '0;
  logic [7:0] last_addr = '0;

  always @(posedge mem_clk or negedge mem_cs) begin
    int maw;
    maw = model_wide ? 8 : 6;
    if (!mem_cs) begin
      last_edges = m_edges;
      last_op    = m_op;
      last_addr  = m_addr;
      m_edges = 0;
      m_op    = '0;
      m_addr  = '0;
      miso_r <= #1 1'b0;
    end else begin
      m_edges++;
      if (m_edges <= 3) m_op = {m_op[1:0], mem_mosi};
      else if (m_edges <= 3 + maw) m_addr = {m_addr[6:0], mem_mosi};
      if (m_edges == 3 + maw) m_word = ref_word(m_addr, model_wide);
      if (m_edges > 3 + maw && m_edges <= 3 + maw + 16)
        miso_r <= #1 m_word[15 - (m_edges - 4 - maw)];
      else
        miso_r <= #1 1'b0;
    end
  end

  // ---------------- pin monitors (sampled at falling edge) ----------------
  int hi_run = 0, cs_low_run = 0;
  int phase_err = 0, mosi_err = 0, cs_err = 0;
  logic p_clk = 1'b0, p_mosi = 1'b0, p_cs = 1'b0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (mem_clk) hi_run++;
      else begin
        if (hi_run != 0 && hi_run != PH) phase_err++;
        hi_run = 0;
      end
      if (mem_clk && p_clk && mem_mosi != p_mosi) mosi_err++;
      if (mem_cs && !p_cs && mem_clk) cs_err++;
      if (!mem_cs && p_cs && (mem_clk || p_clk)) cs_err++;
      if (mem_cs) cs_low_run = 0; else cs_low_run++;
    end
    p_clk = mem_clk; p_mosi = mem_mosi; p_cs = mem_cs;
  end

  // ---------------- request helper ----------------
  task automatic issue(input logic au, input logic wd, input logic [7:0] ad);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_auto = au; req_wide = wd; req_addr = ad;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic wait_rsp();
    while (!rsp_valid) @(negedge clk);
  endtask

  // fields: [11] auto, [10] wide, [9] model wide, [8] expected rsp_wide, [7:0] addr
  localparam logic [11:0] VEC [0:7] = '{
    {4'b0111, 8'hA7},
    {4'b0111, 8'h00},
    {4'b0111, 8'hFF},
    {4'b0000, 8'h15},
    {4'b0000, 8'hEA},
    {4'b1011, 8'h3C},
    {4'b1100, 8'hEB},
    {4'b0000, 8'h3F}
  };

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check(mem_cs == 0 && mem_clk == 0 && mem_mosi == 0, "R1 memory pins idle", {mem_cs, mem_clk, mem_mosi}, 0);
    check(rsp_valid == 0 && busy == 0, "R1 no response, not busy", {rsp_valid, busy}, 0);
    check(req_ready == 1, "R1 ready after reset", req_ready, 1);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    for (int v = 0; v < 8; v++) begin
      logic au, wd, mw, ew;
      logic [7:0] ad, sent;
      au = VEC[v][11]; wd = VEC[v][10]; mw = VEC[v][9]; ew = VEC[v][8]; ad = VEC[v][7:0];
      model_wide = mw;
      phase_err = 0; mosi_err = 0; cs_err = 0;
      issue(au, wd, ad);
      wait_rsp();
      sent = ew ? ad : {2'b00, ad[5:0]};
      check(rsp_data == ref_word(ad, ew), $sformatf("R5 R2 word vec %0d", v), rsp_data, ref_word(ad, ew));
      check(rsp_wide == ew, $sformatf("R6 width vec %0d", v), rsp_wide, ew);
      check(last_op == 3'b110, $sformatf("R2 opcode vec %0d", v), last_op, 3'b110);
      check(last_addr == sent, $sformatf("R2 address vec %0d", v), last_addr, sent);
      check(last_edges == (ew ? 27 : 25), $sformatf("R5 edge count vec %0d", v), last_edges, ew ? 27 : 25);
      check(phase_err == 0 && mosi_err == 0, $sformatf("R4 phases vec %0d", v), phase_err + mosi_err, 0);
      check(cs_err == 0, $sformatf("R3 select edges vec %0d", v), cs_err, 0);
      check(cs_low_run >= PH && !busy, $sformatf("R8 deselect before response vec %0d", v), cs_low_run, PH);
      @(negedge clk);
    end

    // R8 busy rises the cycle after acceptance
    model_wide = 1'b1;
    @(negedge clk);
    req_valid = 1'b1; req_auto = 1'b0; req_wide = 1'b1; req_addr = 8'h42;
    @(negedge clk);
    req_valid = 1'b0;
    check(busy == 1'b1, "R8 busy after accept", busy, 1);
    check(req_ready == 1'b0, "R7 not ready while busy", req_ready, 0);
    wait_rsp();
    @(negedge clk);

    // R7 back-pressure
    rsp_ready = 1'b0;
    issue(1'b0, 1'b1, 8'h81);
    wait_rsp();
    begin
      logic [15:0] held;
      int slips;
      held = rsp_data;
      slips = 0;
      req_valid = 1'b1; req_addr = 8'h05; req_wide = 1'b1;
      for (int k = 0; k < 12; k++) begin
        @(negedge clk);
        if (!rsp_valid || rsp_data != held || req_ready || mem_cs) slips++;
      end
      check(slips == 0, "R7 response held, request refused", slips, 0);
      check(held == ref_word(8'h81, 1'b1), "R7 held word", held, ref_word(8'h81, 1'b1));
      req_valid = 1'b0;
      @(negedge clk);
      rsp_ready = 1'b1;
      @(negedge clk);
      check(rsp_valid == 1'b0 && mem_cs == 1'b0, "R7 response taken", {rsp_valid, mem_cs}, 0);
      check(req_ready == 1'b1, "R7 ready again", req_ready, 1);
    end

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule